// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block tracks how trustworthy a CAN node is on the bus. The protocol engine sends it single-cycle event pulses: transmit error, receive error, successful transmit, successful receive, and a qualifier. The qualifier marks an event that happened in the bit-rate-switched data phase of an FD frame. From these pulses the block keeps a transmit counter and a receive counter, and from them derives whether the node is error active, error passive or bus off.

A second pair of counters follows the same rules, but only for events in the fast data phase. These counters saturate at 255 and freeze while the node is bus off. In the low-power networking mode, the transmit side holds still and the receive side keeps counting. The 32-bit counter view and the sticky error flags stay frozen until normal mode resumes.

Top module: `can_fault_counters`

## Requirements
- R1: A transmit error adds 8 to the transmit counter. A successful transmit without a same-cycle transmit error subtracts 1, and the counter never goes below 0.
- R2: A receive error adds 1 to the receive counter. Once the counter is above 127 (it reaches 128), further receive errors leave it unchanged.
- R3: A successful receive without a same-cycle receive error behaves as follows. If the receive counter is above 127, it is loaded with 127. Otherwise it is decremented, and it never goes below 0.
- R4: `state_o` encodes the fault-confinement state. 2'b00 means error active: both counters are at most 127. 2'b01 means error passive: either counter is above 127 and the transmit counter is at most 255. 2'b10 means bus off: the transmit counter is above 255. The state follows the counters in the same cycle in which they change.
- R5: While the node is bus off, every event pulse is ignored by all four counters and all flags. A `recov_done_i` pulse during bus off clears all four counters, and the node becomes error active.
- R6: The fast counters change only on events with `fast_i`=1. They use the same +8 (transmit), +1 (receive) and -1 (success) steps, saturate at 255 and never wrap. The receive limit of R2 and the reload of R3 do not apply to them. The normal counters see the same events as well.
- R7: While `lp_mode_i`=1, both transmit counters hold their values and both receive counters keep counting.
- R8: `err_view_o` packs four bytes. Bits 31:24 hold the fast receive counter and bits 23:16 the fast transmit counter. Bits 15:8 hold the receive counter. Bits 7:0 hold the transmit counter, shown as 255 when it is above 255. The view resets to zero. It is updated on the clock edge after a counter change, is frozen while `lp_mode_i`=1, and catches up one edge after `lp_mode_i` returns to 0.
- R9: `flags_o` holds sticky flags: bit 0 for transmit error, bit 1 for receive error, bit 2 for fast transmit error, bit 3 for fast receive error. A flag is set by the matching error pulse and cleared by `flag_clr_i`, and a same-cycle set wins over the clear. The flags are delayed and frozen with the same timing as `err_view_o`.
- R10: Error pulses that arrive while `lp_mode_i`=1 never set the fast flags (bits 2 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_err_i | input | 1 | Transmit error pulse |
| rx_err_i | input | 1 | Receive error pulse |
| tx_ok_i | input | 1 | Successful transmit pulse |
| rx_ok_i | input | 1 | Successful receive pulse |
| fast_i | input | 1 | Event occurred in bit-rate-switched data phase |
| lp_mode_i | input | 1 | Low-power networking mode active |
| recov_done_i | input | 1 | Bus-off recovery sequence completed |
| flag_clr_i | input | 1 | Clear sticky error flags |
| state_o | output | 2 | Fault-confinement state |
| err_view_o | output | 32 | Packed counter view |
| flags_o | output | 4 | Sticky error flags |

## Verification
Each event pulse is sampled on one rising edge, and the counters and `state_o` reflect it right after that edge. `err_view_o` and `flags_o` follow one edge later. The bench drives every pulse for exactly one cycle at a falling edge, checks the state after the next falling edge, and compares the view and flags only after one further edge. During low-power mode the expected view is held at the last snapshot taken in normal mode. It is refreshed only once a full edge has passed with the mode released.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUS_OFF = 2'b10
  } fc_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_FLAGS = 4;
endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
  parameter int unsigned W          = 8,
  parameter int unsigned INC        = 1,
  parameter int unsigned CAP        = 255,
  parameter int unsigned MAXV       = 255,
  parameter bit          RELOAD_EN  = 1'b0,
  parameter int unsigned RELOAD_THR = 127,
  parameter int unsigned RELOAD_VAL = 127
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  cnt_q, cnt_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + SW'(INC);
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      if (cnt_q >= W'(CAP))       cnt_d = cnt_q;         // stop counting at cap
      else if (sum > SW'(MAXV))   cnt_d = W'(MAXV);      // saturate
      else                        cnt_d = sum[W-1:0];
    end else if (dec_i) begin
      if (RELOAD_EN && cnt_q > W'(RELOAD_THR)) cnt_d = W'(RELOAD_VAL);
      else if (cnt_q != '0)                    cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_inc_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (cnt_q >= $past(cnt_q)));

  p_dec_floor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && !clr_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/can_fc_snap.sv
module can_fc_snap #(
  parameter int unsigned W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters
  import can_fc_pkg::*;
#(
  parameter int unsigned TX_STEP     = 8,
  parameter int unsigned RX_STEP     = 1,
  parameter int unsigned PASSIVE_LIM = 127,
  parameter int unsigned RX_RELOAD   = 127
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_err_i,
  input  logic        rx_err_i,
  input  logic        tx_ok_i,
  input  logic        rx_ok_i,
  input  logic        fast_i,
  input  logic        lp_mode_i,
  input  logic        recov_done_i,
  input  logic        flag_clr_i,
  output logic [1:0]  state_o,
  output logic [31:0] err_view_o,
  output logic [3:0]  flags_o
);
  localparam int unsigned BO_LIM  = 255;
  localparam int unsigned TEC_W   = BYTE_W + 1;
  localparam int unsigned FAST_MX = (1 << BYTE_W) - 1;
  localparam int unsigned VIEW_W  = 4 * BYTE_W;
  localparam int unsigned SNAP_W  = VIEW_W + NUM_FLAGS;

  logic [TEC_W-1:0]  tec_q;
  logic [BYTE_W-1:0] rec_q, ftx_q, frx_q, tec_byte;
  logic              bus_off, live, tx_live, clr_all;
  logic [3:0]        fl_q, fl_set;
  fc_state_e         state;

  assign bus_off = tec_q > TEC_W'(BO_LIM);
  assign live    = !bus_off;
  assign tx_live = live && !lp_mode_i;
  assign clr_all = bus_off && recov_done_i;

  can_fc_counter #(.W(TEC_W), .INC(TX_STEP), .CAP(BO_LIM + 1), .MAXV((1 << TEC_W) - 1))
  u_tec (.clk_i, .rst_ni, .clr_i(clr_all),
         .inc_i(tx_live && tx_err_i), .dec_i(tx_live && tx_ok_i && !tx_err_i),
         .cnt_o(tec_q));

  can_fc_counter #(.W(BYTE_W), .INC(RX_STEP), .CAP(PASSIVE_LIM + 1), .MAXV(FAST_MX),
                   .RELOAD_EN(1'b1), .RELOAD_THR(PASSIVE_LIM), .RELOAD_VAL(RX_RELOAD))
  u_rec (.clk_i, .rst_ni, .clr_i(clr_all),
         .inc_i(live && rx_err_i), .dec_i(live && rx_ok_i && !rx_err_i),
         .cnt_o(rec_q));

  can_fc_counter #(.W(BYTE_W), .INC(TX_STEP), .CAP(FAST_MX), .MAXV(FAST_MX))
  u_ftx (.clk_i, .rst_ni, .clr_i(clr_all),
         .inc_i(tx_live && fast_i && tx_err_i),
         .dec_i(tx_live && fast_i && tx_ok_i && !tx_err_i),
         .cnt_o(ftx_q));

  can_fc_counter #(.W(BYTE_W), .INC(RX_STEP), .CAP(FAST_MX), .MAXV(FAST_MX))
  u_frx (.clk_i, .rst_ni, .clr_i(clr_all),
         .inc_i(live && fast_i && rx_err_i),
         .dec_i(live && fast_i && rx_ok_i && !rx_err_i),
         .cnt_o(frx_q));

  always_comb begin
    if (bus_off)                                               state = FC_BUS_OFF;
    else if (tec_q > TEC_W'(PASSIVE_LIM) || rec_q > BYTE_W'(PASSIVE_LIM)) state = FC_PASSIVE;
    else                                                       state = FC_ACTIVE;
  end
  assign state_o = state;

  // sticky flags; fast flags blocked in low-power mode
  assign fl_set = {live && !lp_mode_i && fast_i && rx_err_i,
                   tx_live && fast_i && tx_err_i,
                   live && rx_err_i,
                   tx_live && tx_err_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fl_q <= '0;
    else         fl_q <= (fl_q & ~{4{flag_clr_i}}) | fl_set;
  end

  assign tec_byte = tec_q[BYTE_W] ? '1 : tec_q[BYTE_W-1:0];

  can_fc_snap #(.W(SNAP_W)) u_snap (
    .clk_i, .rst_ni, .hold_i(lp_mode_i),
    .d_i({fl_q, frx_q, ftx_q, rec_q, tec_byte}),
    .q_o({flags_o, err_view_o}));

  p_tec_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_err_i && !lp_mode_i && !bus_off) |=> (tec_q == $past(tec_q) + TEC_W'(TX_STEP)));

  p_rec_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_q <= BYTE_W'(PASSIVE_LIM + 1));

  p_rx_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ok_i && !rx_err_i && !bus_off && rec_q > BYTE_W'(PASSIVE_LIM))
      |=> (rec_q == BYTE_W'(RX_RELOAD)));

  p_bo_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off && !recov_done_i) |=> ($stable(tec_q) && $stable(rec_q) && $stable(ftx_q) && $stable(frx_q)));

  p_lp_tx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i && !clr_all) |=> ($stable(tec_q) && $stable(ftx_q)));

  p_view_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_mode_i |=> ($stable(err_view_o) && $stable(flags_o)));

  p_fast_flag_lp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i && fl_q[3:2] == 2'b00) |=> (fl_q[3:2] == 2'b00));
endmodule

// File: tb/can_fault_counters_tb.sv
module can_fault_counters_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, fast = 0;
  logic lp_mode = 0, recov_done = 0, flag_clr = 0;
  logic [1:0]  state;
  logic [31:0] view;
  logic [3:0]  flags;

  int n_chk = 0, n_fail = 0;
  int m_tec = 0, m_rec = 0, m_ftx = 0, m_frx = 0;
  logic [3:0]  m_fl = '0;
  logic [31:0] vexp = '0;
  logic [3:0]  fexp = '0;
  bit lp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_fault_counters u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err),
    .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .fast_i(fast), .lp_mode_i(lp_mode),
    .recov_done_i(recov_done), .flag_clr_i(flag_clr),
    .state_o(state), .err_view_o(view), .flags_o(flags));

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic logic [31:0] pack();
    return {8'(m_frx), 8'(m_ftx), 8'(m_rec), 8'(sat(m_tec))};
  endfunction

  function automatic logic [1:0] st_exp();
    if (m_tec > 255) return 2'b10;
    if (m_tec > 127 || m_rec > 127) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ev(input bit te, input bit re, input bit to, input bit ro, input bit f);
    bit bo;
    @(negedge clk);
    tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; fast = f;
    @(negedge clk);
    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; fast = 0;
    bo = m_tec > 255;
    if (!bo) begin
      if (te && !lp) m_tec += 8;
      else if (to && !lp && m_tec > 0) m_tec--;
      if (re) begin if (m_rec <= 127) m_rec++; end
      else if (ro) begin if (m_rec > 127) m_rec = 127; else if (m_rec > 0) m_rec--; end
      if (f) begin
        if (te && !lp) m_ftx = sat(m_ftx + 8);
        else if (to && !lp && m_ftx > 0) m_ftx--;
        if (re) m_frx = sat(m_frx + 1);
        else if (ro && m_frx > 0) m_frx--;
      end
      if (te && !lp) m_fl[0] = 1'b1;
      if (re) m_fl[1] = 1'b1;
      if (f && te && !lp) m_fl[2] = 1'b1;
      if (f && re && !lp) m_fl[3] = 1'b1;
    end
  endtask

  // compares state now, view and flags after the extra snapshot edge
  task automatic chk(input string tag);
    check({tag, " state R4"}, 32'(state), 32'(st_exp()));
    @(negedge clk);
    if (!lp) begin vexp = pack(); fexp = m_fl; end
    check({tag, " view R8"}, view, vexp);
    check({tag, " flags R9"}, 32'(flags), 32'(fexp));
  endtask

  task automatic set_lp(input bit v);
    @(negedge clk);
    lp_mode = v; lp = v;
  endtask

  task automatic t_reset();
    check("reset view R8", view, 32'h0);
    check("reset state R4", 32'(state), 32'h0);
    check("reset flags R9", 32'(flags), 32'h0);
  endtask

  task automatic t_tx_steps();
    for (int i = 0; i < 3; i++) ev(1, 0, 0, 0, 0);
    ev(0, 0, 1, 0, 0);
    chk("tx steps R1");
    check("tx literal R1", view, 32'h0000_0017);
    for (int i = 0; i < 25; i++) ev(0, 0, 1, 0, 0);
    chk("tx floor R1");
    check("tx floor literal R1", 32'(view[7:0]), 32'h0);
  endtask

  task automatic t_rx_rules();
    for (int i = 0; i < 130; i++) ev(0, 1, 0, 0, 0);
    chk("rx cap R2");
    check("rx cap literal R2", 32'(view[15:8]), 32'h80);
    check("passive R4", 32'(state), 32'h1);
    ev(0, 0, 0, 1, 0);
    chk("rx reload R3");
    check("active after reload R4", 32'(state), 32'h0);
    ev(0, 0, 0, 1, 0);
    chk("rx dec R3");
    check("rx dec literal R3", 32'(view[15:8]), 32'd126);
  endtask

  task automatic t_fast();
    for (int i = 0; i < 10; i++) ev(1, 0, 0, 0, 1);
    for (int i = 0; i < 300; i++) ev(0, 1, 0, 0, 1);
    chk("fast sat R6");
    check("fast literal R6", view, 32'hFF50_8050);
    ev(0, 0, 1, 0, 1);
    chk("fast dec R6");
    ev(1, 0, 0, 0, 0);
    chk("fast unqualified R6");
    check("fast tx held R6", 32'(view[23:16]), 32'h4F);
  endtask

  task automatic t_flags();
    check("flags all set R9", 32'(flags), 32'hF);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; m_fl = '0;
    chk("flags cleared R9");
    check("flags zero R9", 32'(flags), 32'h0);
  endtask

  task automatic t_lowpower();
    for (int i = 0; i < 6; i++) ev(0, 0, 0, 1, 0);
    chk("pre lp");
    set_lp(1);
    for (int i = 0; i < 3; i++) ev(1, 1, 0, 0, 1);
    ev(0, 0, 1, 0, 1);
    chk("lp frozen view R8");
    set_lp(0);
    chk("lp catch up R7");
    check("lp tx held R7", 32'(view[7:0]), 32'h57);
    check("lp rx counted R7", 32'(view[15:8]), 32'd125);
    check("lp no fast flags R10", 32'(flags), 32'h2);
  endtask

  task automatic t_busoff();
    while (m_tec <= 255) ev(1, 0, 0, 0, 1);
    chk("bus off R5");
    check("bus off state R5", 32'(state), 32'h2);
    check("bus off tec byte R8", 32'(view[7:0]), 32'hFF);
    ev(0, 1, 0, 0, 1);
    ev(0, 0, 1, 1, 1);
    chk("bus off ignore R5");
    @(negedge clk); recov_done = 1'b1;
    @(negedge clk); recov_done = 1'b0;
    m_tec = 0; m_rec = 0; m_ftx = 0; m_frx = 0;
    chk("recovery R5");
    check("recovery literal R5", view, 32'h0);
    check("recovery active R5", 32'(state), 32'h0);
    ev(1, 0, 0, 0, 1);
    chk("recount after recovery R6");
  endtask

  initial begin
    #1;
    t_reset();
    #11 rst_n = 1'b1;
    t_tx_steps();
    t_rx_rules();
    t_fast();
    t_flags();
    t_lowpower();
    t_busoff();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule